// File: doc/BRIEF.md
# Round-Robin Interleaved DAC Feeder

This block takes one stream of signed 4-bit samples arriving at the full output rate and deals them out over several slower converter lanes. Each accepted sample goes to the next lane in a fixed rotation. The lane then presents that sample for a fixed window of cycles, and the windows of neighbouring lanes are offset by one output cycle. With four lanes in return-to-zero operation, each lane is active for half of its own lane period, so two neighbouring lanes are active at once. The analog sum of the lanes therefore follows x(n)+x(n-1), which puts a zero at half the output rate.

A second operating mode uses only two lanes and models hold-type converters that share one clock. Even samples go to the first lane and odd samples to the second. Each sample is stretched over two output cycles, and the second lane trails the first by one cycle, so the active time of one lane fills the gap of the other. The mode is captured while reset is asserted and is fixed for the rest of the run. Cycles without a valid input load no lane. A window that expires is not refilled, so its lane returns to zero and no old value is shown again.

The outputs are one digital code per lane, a per-lane active strobe that marks the lane's high phase, and a per-lane load strobe. The analog summation, clock-skew trimming and jitter handling sit outside this block.

Top module: `il_dac_feeder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every lane code, active strobe and load strobe is zero. The first valid sample after reset always goes to lane 0.
- R2: With mode_i = 0 (four-lane return-to-zero), consecutive valid samples go to lanes 0, 1, 2, 3 and then wrap back to lane 0.
- R3: A sample accepted on a clock edge appears on its lane's code field (bits [4k+3:4k] for lane k, two's complement) from the next cycle on, for exactly 2 cycles. The lane's active strobe is high for those cycles. After that the lane outputs zero until it is written again.
- R4: In four-lane mode, no more than NUM_LANES/2 lanes are active in any cycle. With a continuous valid stream, the signed sum of all lane codes equals x(n)+x(n-1), where x(n) is the most recently accepted sample.
- R5: With mode_i = 1 (two-lane hold), even-numbered samples after reset go to lane 0 and odd-numbered samples to lane 1. Lanes 2 and 3 stay zero and inactive.
- R6: In two-lane mode, each sample is held for 2 cycles and lane 1 is loaded one cycle after lane 0. Under a continuous valid stream, both lanes are active in every cycle once both have been loaded.
- R7: A cycle with valid_i low loads no lane and does not advance the rotation. Lanes whose windows expire output zero.
- R8: mode_i is sampled only while rst_ni is low. A change of mode_i after reset has no effect on lane assignment.
- R9: lane_load_o[k] is high for exactly one cycle, the first cycle of lane k's window, and at most one lane shows a load in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Full output-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset; mode_i is captured while it is low |
| mode_i | input | 1 | 0 = four-lane return-to-zero, 1 = two-lane hold |
| valid_i | input | 1 | Sample on sample_i is accepted on this edge |
| sample_i | input | 4 | Signed input sample |
| lane_code_o | output | 16 | Per-lane codes; lane k occupies bits [4k+3:4k] |
| lane_high_o | output | 4 | Per-lane active (clock-high) strobe |
| lane_load_o | output | 4 | Per-lane strobe for the first cycle of a new window |

## Verification
The assertions assume that mode_i is held steady while rst_ni is low, so that the captured mode reflects an intended setting. They also assume NUM_LANES is a power of two of at least four, so that the rotation wraps cleanly and a lane's window always ends before the lane is written again. The bench changes mode only across a reset and holds the mode input steady for several clocks of each reset pulse. The random runs mix long valid bursts with gaps, and in one run mode_i is deliberately toggled after reset to show that it is ignored.

// File: rtl/il_dac_pkg.sv
package il_dac_pkg;
  typedef enum logic {
    MODE_RZ4   = 1'b0,
    MODE_HOLD2 = 1'b1
  } il_mode_e;
endpackage

// File: rtl/il_lane_ptr.sv
module il_lane_ptr
  import il_dac_pkg::*;
#(
  parameter int NUM_LANES = 4,
  localparam int PTR_W = $clog2(NUM_LANES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  il_mode_e         mode_i,
  input  logic             valid_i,
  output logic [PTR_W-1:0] ptr_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
    end else if (valid_i) begin
      if (mode_i == MODE_HOLD2) ptr_o <= (ptr_o == PTR_W'(1)) ? '0 : PTR_W'(1);
      else                      ptr_o <= ptr_o + PTR_W'(1);
    end
  end

  assert_ptr_moves_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ptr_o != $past(ptr_o));

  assert_ptr_still_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(ptr_o));

  assert_ptr_two_lanes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_HOLD2 |-> ptr_o < PTR_W'(2));

endmodule

// File: rtl/il_lane_slot.sv
module il_lane_slot #(
  parameter int DATA_W = 4,
  parameter int CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0]  win_len_i,
  output logic [DATA_W-1:0] code_o,
  output logic              high_o,
  output logic              load_o
);

  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      cnt_q  <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= wr_en_i;
      if (wr_en_i) begin
        data_q <= wr_data_i;
        cnt_q  <= win_len_i;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign high_o = (cnt_q != '0);
  assign load_o = load_q;
  // return-to-zero outside the window
  assign code_o = high_o ? data_q : '0;

  assert_slot_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (high_o && load_o && code_o == $past(wr_data_i)));

  assert_slot_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (high_o && !load_o) |-> $stable(code_o));

  assert_slot_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && !wr_en_i) |=> !load_o);

endmodule

// File: rtl/il_dac_feeder.sv
module il_dac_feeder
  import il_dac_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int DATA_W    = 4,
  localparam int PTR_W    = $clog2(NUM_LANES),
  localparam int HALF     = NUM_LANES / 2,
  localparam int CNT_W    = $clog2(HALF + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        mode_i,
  input  logic                        valid_i,
  input  logic [DATA_W-1:0]           sample_i,
  output logic [NUM_LANES*DATA_W-1:0] lane_code_o,
  output logic [NUM_LANES-1:0]        lane_high_o,
  output logic [NUM_LANES-1:0]        lane_load_o
);

  il_mode_e         mode_q;
  logic [PTR_W-1:0] ptr;
  logic [CNT_W-1:0] win_len;
  logic [NUM_LANES-1:0] wr_en;

  // mode is only captured while held in reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= il_mode_e'(mode_i);
  end

  assign win_len = (mode_q == MODE_HOLD2) ? CNT_W'(2) : CNT_W'(HALF);

  il_lane_ptr #(.NUM_LANES(NUM_LANES)) i_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_q),
    .valid_i (valid_i),
    .ptr_o   (ptr)
  );

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    assign wr_en[k] = valid_i && (ptr == PTR_W'(k));

    il_lane_slot #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en[k]),
      .wr_data_i (sample_i),
      .win_len_i (win_len),
      .code_o    (lane_code_o[k*DATA_W +: DATA_W]),
      .high_o    (lane_high_o[k]),
      .load_o    (lane_load_o[k])
    );
  end

  assert_overlap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(lane_high_o) <= HALF);

  assert_one_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lane_load_o));

  assert_upper_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == MODE_HOLD2 |-> lane_high_o[NUM_LANES-1:2] == '0);

  assert_hold_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_HOLD2 && lane_load_o[0] && valid_i) |=> lane_load_o[1]);

endmodule

// File: tb/test_il_dac_feeder.sv
module test_il_dac_feeder;
  localparam int NL = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  smp = '0;
  logic [15:0] code;
  logic [3:0]  high, load;

  int n_run = 0, n_fail = 0;

  logic [3:0] m_data [NL];
  int         m_cnt  [NL];
  logic [3:0] m_load;
  int         m_ptr;
  bit         m_hold;
  logic [3:0] prev_s, cur_s;

  always #2 clk = ~clk;

  il_dac_feeder i_il_dac_feeder (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .valid_i(valid),
    .sample_i(smp), .lane_code_o(code), .lane_high_o(high), .lane_load_o(load)
  );

  function automatic logic [15:0] exp_code();
    logic [15:0] r = '0;
    for (int k = 0; k < NL; k++) if (m_cnt[k] > 0) r[k*4 +: 4] = m_data[k];
    return r;
  endfunction

  function automatic logic [3:0] exp_high();
    logic [3:0] r = '0;
    for (int k = 0; k < NL; k++) r[k] = (m_cnt[k] > 0);
    return r;
  endfunction

  task automatic do_reset(input bit md);
    @(negedge clk);
    rst_n = 1'b0; mode = md; valid = 1'b0; smp = '0;
    m_hold = md; m_ptr = 0; m_load = '0;
    for (int k = 0; k < NL; k++) begin m_cnt[k] = 0; m_data[k] = '0; end
    repeat (3) @(negedge clk);
    n_run++;
    if (code !== '0 || high !== '0 || load !== '0) begin
      n_fail++;
      $display("FAIL R1 in reset: code=%h high=%b load=%b exp 0", code, high, load);
    end
    rst_n = 1'b1;
  endtask

  // drive one cycle, update the model at the edge, compare at the next negedge
  task automatic step(input bit v, input logic [3:0] s, input string tag);
    valid = v; smp = s;
    @(posedge clk);
    m_load = '0;
    for (int k = 0; k < NL; k++) if (m_cnt[k] > 0) m_cnt[k]--;
    if (v) begin
      m_data[m_ptr] = s; m_cnt[m_ptr] = 2; m_load[m_ptr] = 1'b1;
      m_ptr = m_hold ? (m_ptr == 1 ? 0 : 1) : (m_ptr + 1) % NL;
      prev_s = cur_s; cur_s = s;
    end
    @(negedge clk);
    n_run++;
    if (code !== exp_code() || high !== exp_high() || load !== m_load) begin
      n_fail++;
      $display("FAIL %s: code=%h high=%b load=%b exp code=%h high=%b load=%b",
               tag, code, high, load, exp_code(), exp_high(), m_load);
    end
  endtask

  task automatic check_sum(input string tag);
    int sum = 0;
    for (int k = 0; k < NL; k++) sum += int'($signed(code[k*4 +: 4]));
    n_run++;
    if (sum != int'($signed(cur_s)) + int'($signed(prev_s))) begin
      n_fail++;
      $display("FAIL %s sum: got %0d exp %0d", tag, sum,
               int'($signed(cur_s)) + int'($signed(prev_s)));
    end
  endtask

  initial begin
    #(4ns * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    prev_s = '0; cur_s = '0;

    // R1: reset state and first sample to lane 0
    do_reset(1'b0);
    step(1'b0, 4'h0, "R1 idle after reset");
    step(1'b1, 4'h7, "R1 first sample lane 0");
    step(1'b0, 4'h0, "R3 second window cycle");
    step(1'b0, 4'h0, "R3 return to zero");

    // R2 rotation and R4 overlap sum, continuous stream
    do_reset(1'b0);
    for (int i = 0; i < 10; i++) begin
      step(1'b1, 4'(i + 9), "R2 rotation");
      if (i > 0) check_sum("R4");
    end
    // extremes: most negative and most positive codes
    step(1'b1, 4'h8, "R4 min code"); check_sum("R4 min");
    step(1'b1, 4'h8, "R4 min pair"); check_sum("R4 min pair");
    step(1'b1, 4'h7, "R4 max code"); check_sum("R4 max");

    // R7 gaps: no advance, windows expire to zero
    step(1'b0, 4'h5, "R7 gap 1");
    step(1'b0, 4'h5, "R7 gap 2");
    step(1'b0, 4'h5, "R7 gap 3");
    step(1'b1, 4'h3, "R7 resume next lane");

    // R5/R6 two-lane hold mode
    do_reset(1'b1);
    for (int i = 0; i < 8; i++) step(1'b1, 4'(3 * i + 1), "R5 R6 two-lane stream");
    step(1'b0, 4'h0, "R6 tail");
    step(1'b0, 4'h0, "R6 both zero");

    // R8: mode_i changed after reset is ignored
    do_reset(1'b0);
    mode = 1'b1;
    for (int i = 0; i < 6; i++) step(1'b1, 4'(i + 2), "R8 mode held from reset");
    do_reset(1'b1);
    mode = 1'b0;
    for (int i = 0; i < 6; i++) step(1'b1, 4'(i + 4), "R8 hold kept after reset");

    // random mixes in both modes, R9 load pulses checked each step
    for (int r = 0; r < 6; r++) begin
      do_reset(bit'(r % 2));
      for (int i = 0; i < 300; i++)
        step(bit'(($urandom % 4) != 0), 4'($urandom), "R9 R3 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule